// File: doc/BRIEF.md
# Deserializer Lock and Output-State Controller

This controller sequences the back end of a serial video receiver from power-down to valid data. When the receiver is powered up, it first waits for the reference PLL to settle. It then searches the serial stream for a transition word. Once it has locked, it watches for that word to keep recurring. At each step it tells the parallel-output stage three things: whether to drive its pins at all, whether to force the data pins low, and which clock to put on the parallel clock pin.

The clock pin carries the local reference clock until the first transition word is found. It then carries the clock recovered from the serial input. Every change of clock source, in either direction, is announced by a one-cycle stretch request to the clock multiplexer. The new source select is applied only on the following cycle. Reference lock ends on a pulse from the PLL or on an internal cycle bound, whichever comes first. Setting the bound to zero leaves only the pulse.

Top module: `deser_lock_ctrl`

## Requirements
- R1: During reset, `drv_en`, `pll_run`, `clk_sel` and `stretch_req` are all 0.
- R2: While `pwr_n` is low, `drv_en` is 0 in the same cycle and `pll_run` is 0 from the next clock edge. The clock select returns to the reference clock (0) one edge later, with no stretch request.
- R3: On the first edge with `pwr_n` high, the block leaves power-down. It sets `pll_run`=1, `lock_n`=1, `force_low`=1 and `clk_sel`=0, and sets `drv_en`=1 if `oe` is high.
- R4: The reference-lock phase lasts exactly `REF_LOCK_CYCLES` cycles. If `ref_locked` is seen before then, the phase ends on the edge that samples it.
- R5: In the search phase, a `xword_found` strobe with `in_active` high drives `lock_n` low on the next edge.
- R6: Every change of `clk_sel` while powered is preceded by exactly one cycle of `stretch_req`. Here `clk_sel` is 1 for the recovered clock and 0 for the reference clock. `clk_sel` toggles on the edge that ends the stretch.
- R7: While locked, if `TIMEOUT_CYCLES` consecutive edges sample no `xword_found`, `lock_n` goes high and the clock switches back to the reference clock. Searching then resumes, and a single strobe relocks. A gap of exactly `TIMEOUT_CYCLES` between strobes keeps the lock.
- R8: While searching or locked, `in_active` low makes `lock_n` high on the next edge. `lock_n` stays high, ignoring `xword_found`, until `in_active` returns. After that, searching resumes.
- R9: `oe` low forces `drv_en` to 0 in the same cycle without changing the sequencing state. When `oe` returns high, `lock_n` shows the unchanged lock state.
- R10: During the reference-lock phase, `xword_found` and `in_active` have no effect.
- R11: While powered, `force_low` equals `lock_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_n | input | 1 | Low requests power-down |
| oe | input | 1 | Output enable; low tristates every output |
| ref_locked | input | 1 | Pulse from the reference PLL when it has locked |
| xword_found | input | 1 | Transition-word-found strobe from the word aligner |
| in_active | input | 1 | High while the serial input is switching |
| lock_n | output | 1 | Lock flag, low when output data is valid |
| clk_sel | output | 1 | Parallel clock source: 0 reference, 1 recovered |
| stretch_req | output | 1 | One-cycle request to stretch the parallel clock |
| drv_en | output | 1 | Drive enable for all output pins; low means high impedance |
| force_low | output | 1 | Forces data, control and data-enable pins low |
| pll_run | output | 1 | Lets the PLL run; low holds it stopped |

## Verification
The bench sweeps the arrival cycle of the PLL-locked pulse across the whole reference-lock window and past its end. A controller that ignored the pulse, or ended the window one cycle off, would relock at the wrong edge. It tests strobe gaps of exactly the timeout window and of one cycle more. An off-by-one watchdog would drop lock on the first gap or keep lock on the second. It follows the stretch request and the select cycle by cycle through both clock switches. A design that moved the select together with the request, or skipped the return stretch, is caught there. Idle input, output-enable toggling while locked, and power-down during lock each check that the lock flag comes back in the right state.

// File: rtl/deser_lock_pkg.sv
`timescale 1ns/1ps
// Shared types of the lock controller.
// Assumes: one clock domain for all sequencing.
package deser_lock_pkg;

    typedef enum logic [2:0] {
        ST_OFF     = 3'd0,  // powered down, pins tristated
        ST_REFLOCK = 3'd1,  // PLL settling on the reference clock
        ST_HUNT    = 3'd2,  // searching for a transition word
        ST_LOCKED  = 3'd3,  // valid data, recovered clock out
        ST_NOACT   = 3'd4   // serial input not switching
    } lock_state_e;

endpackage

// File: rtl/lock_cycle_timer.sv
`timescale 1ns/1ps
// Saturating cycle counter that raises hit on the cycle it reaches LIMIT-1.
// Counts while run is high, clears on clr or when run is low.
// Assumes: LIMIT >= 1.
module lock_cycle_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clr,
    output logic hit
);
    localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    // Count cycles spent in the watched condition, holding at the top.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !run)
            cnt <= '0;
        else if (cnt != LAST)
            cnt <= cnt + 1'b1;
    end

    assign hit = run && (cnt == LAST);
endmodule

// File: rtl/lock_clk_switch.sv
`timescale 1ns/1ps
// Clock-source select with a stretch request ahead of every change.
// A mismatch between want and the applied select raises a one-cycle
// stretch; the select toggles on the edge that ends it.
// Assumes: pwr_on low returns the select to the reference clock at once.
module lock_clk_switch (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_on,
    input  logic want,
    output logic sel,
    output logic stretch
);
    // Issue the stretch, then apply the new source one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_on) begin
            sel     <= 1'b0;
            stretch <= 1'b0;
        end else if (stretch) begin
            stretch <= 1'b0;
            sel     <= ~sel;
        end else if (want != sel) begin
            stretch <= 1'b1;
        end
    end
endmodule

// File: rtl/deser_lock_ctrl.sv
`timescale 1ns/1ps
// Lock and output-state controller for a serial video receiver.
// Sequences power-down, reference-clock lock, word search and lock,
// and maps the state onto pin drive, force-low and clock-source controls.
// Assumes: strobes are synchronous to clk; REF_LOCK_CYCLES = 0 means the
// PLL pulse alone ends reference lock.
module deser_lock_ctrl #(
    parameter int REF_LOCK_CYCLES = 16385,
    parameter int TIMEOUT_CYCLES  = 1 << 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_n,
    input  logic oe,
    input  logic ref_locked,
    input  logic xword_found,
    input  logic in_active,
    output logic lock_n,
    output logic clk_sel,
    output logic stretch_req,
    output logic drv_en,
    output logic force_low,
    output logic pll_run
);
    import deser_lock_pkg::*;

    lock_state_e state, state_nx;
    logic        in_ref, in_lock, ref_done, word_lost;

    assign in_ref  = (state == ST_REFLOCK);
    assign in_lock = (state == ST_LOCKED);

    // Reference-lock end: bounded by a counter unless the bound is zero.
    generate
        if (REF_LOCK_CYCLES > 0) begin : g_ref_bound
            logic bound_hit;
            lock_cycle_timer #(.LIMIT(REF_LOCK_CYCLES)) u_ref_tmr (
                .clk  (clk),
                .rst_n(rst_n),
                .run  (in_ref),
                .clr  (1'b0),
                .hit  (bound_hit)
            );
            assign ref_done = in_ref && (bound_hit || ref_locked);
        end else begin : g_ref_pulse
            assign ref_done = in_ref && ref_locked;
        end
    endgenerate

    // Watchdog on the recurrence of transition words while locked.
    logic wd_hit;
    lock_cycle_timer #(.LIMIT(TIMEOUT_CYCLES)) u_word_wd (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (in_lock),
        .clr  (xword_found),
        .hit  (wd_hit)
    );
    assign word_lost = wd_hit && !xword_found;

    // Next-state selection; power-down overrides every state.
    always_comb begin
        state_nx = state;
        if (!pwr_n) begin
            state_nx = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:     state_nx = ST_REFLOCK;
                ST_REFLOCK: if (ref_done) state_nx = ST_HUNT;
                ST_HUNT: begin
                    if (!in_active)       state_nx = ST_NOACT;
                    else if (xword_found) state_nx = ST_LOCKED;
                end
                ST_LOCKED: begin
                    if (!in_active)     state_nx = ST_NOACT;
                    else if (word_lost) state_nx = ST_HUNT;
                end
                ST_NOACT:   if (in_active) state_nx = ST_HUNT;
                default:    state_nx = ST_OFF;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    // Clock source follows the lock state through a stretched switch.
    lock_clk_switch u_clk_sw (
        .clk    (clk),
        .rst_n  (rst_n),
        .pwr_on (state != ST_OFF),
        .want   (in_lock),
        .sel    (clk_sel),
        .stretch(stretch_req)
    );

    // Pin-level controls derived from state and the enable inputs.
    always_comb begin
        pll_run   = (state != ST_OFF);
        drv_en    = oe && pwr_n && pll_run;
        lock_n    = !in_lock;
        force_low = !in_lock;
    end
endmodule

// File: rtl/deser_lock_ctrl_checker.sv
`timescale 1ns/1ps
// Property checker for deser_lock_ctrl, attached by bind.
// Assumes: observes only the top-level ports.
module deser_lock_ctrl_checker (
    input logic clk,
    input logic rst_n,
    input logic pwr_n,
    input logic oe,
    input logic ref_locked,
    input logic xword_found,
    input logic in_active,
    input logic lock_n,
    input logic clk_sel,
    input logic stretch_req,
    input logic drv_en,
    input logic force_low,
    input logic pll_run
);
    assert_pwrdn_stops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_n |=> (!pll_run && !drv_en));

    assert_release_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_run) |-> (lock_n && force_low && !clk_sel && !stretch_req));

    assert_lock_needs_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_n) |-> ($past(xword_found) && $past(in_active)));

    assert_stretch_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stretch_req && pll_run) |=> (!stretch_req && (clk_sel != $past(clk_sel))));

    assert_sel_after_stretch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pll_run) && !$stable(clk_sel)) |-> $past(stretch_req));

    assert_idle_drops_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_active && pll_run && !lock_n) |=> lock_n);

    assert_force_tracks_lock_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pll_run |-> (force_low == lock_n));
endmodule

bind deser_lock_ctrl deser_lock_ctrl_checker u_chk (.*);

// File: tb/deser_lock_ctrl_test.sv
`timescale 1ns/1ps
// Self-checking bench for deser_lock_ctrl with a short lock window and timeout.
module deser_lock_ctrl_test;
    localparam int N = 6;
    localparam int T = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0, pwr_n = 1'b0, oe = 1'b1;
    logic ref_locked = 1'b0, xword_found = 1'b0, in_active = 1'b0;
    logic lock_n, clk_sel, stretch_req, drv_en, force_low, pll_run;
    int   total = 0, bad = 0;

    deser_lock_ctrl #(.REF_LOCK_CYCLES(N), .TIMEOUT_CYCLES(T)) uut (
        .clk(clk), .rst_n(rst_n), .pwr_n(pwr_n), .oe(oe),
        .ref_locked(ref_locked), .xword_found(xword_found), .in_active(in_active),
        .lock_n(lock_n), .clk_sel(clk_sel), .stretch_req(stretch_req),
        .drv_en(drv_en), .force_low(force_low), .pll_run(pll_run)
    );

    always #2.5 clk = ~clk;

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic power_cycle();
        pwr_n = 1'b0;
        step();
        step();
        pwr_n = 1'b1;
    endtask

    // Count edges until lock_n falls, pulsing ref_locked after edge ref_at.
    task automatic count_to_lock(input int ref_at, output int edges);
        edges = 0;
        while (lock_n && edges < 60) begin
            if (edges == ref_at) ref_locked = 1'b1;
            step();
            ref_locked = 1'b0;
            edges++;
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int e;
        int k;
        // R1 reset state
        repeat (3) step();
        chk("R1 drv_en", drv_en, 0);
        chk("R1 pll_run", pll_run, 0);
        chk("R1 clk_sel", clk_sel, 0);
        chk("R1 stretch", stretch_req, 0);
        rst_n = 1'b1;
        step();
        step();
        chk("R2 held off drv_en", drv_en, 0);
        chk("R2 held off pll_run", pll_run, 0);

        // R3 release, R4 counter bound, R10 strobes ignored meanwhile
        in_active   = 1'b1;
        xword_found = 1'b1;
        pwr_n       = 1'b1;
        step();
        chk("R3 drv_en", drv_en, 1);
        chk("R3 pll_run", pll_run, 1);
        chk("R3 lock_n", lock_n, 1);
        chk("R3 force_low", force_low, 1);
        chk("R3 clk_sel", clk_sel, 0);
        count_to_lock(-1, e);
        chk("R4 R10 counter bound edges", e + 1, N + 2);
        chk("R5 lock_n low", lock_n, 0);
        chk("R11 force_low on lock", force_low, 0);

        // R6 switch to recovered clock
        chk("R6 sel before stretch", clk_sel, 0);
        chk("R6 no stretch yet", stretch_req, 0);
        step();
        chk("R6 stretch raised", stretch_req, 1);
        chk("R6 sel held during stretch", clk_sel, 0);
        step();
        chk("R6 stretch ends", stretch_req, 0);
        chk("R6 sel recovered", clk_sel, 1);

        // R4 sweep of the PLL pulse arrival
        for (int j = 0; j <= N + 1; j++) begin
            power_cycle();
            count_to_lock(j, e);
            chk($sformatf("R4 pulse at %0d edges", j), e,
                (j >= 1 && j < N) ? j + 2 : N + 2);
        end

        // R7 timeout: last strobe sampled on the locking edge
        xword_found = 1'b0;
        k = 0;
        while (!lock_n && k < 100) begin
            step();
            k++;
        end
        chk("R7 locked cycles before timeout", k, T);
        chk("R11 force_low after timeout", force_low, 1);
        step();
        chk("R7 R6 stretch back", stretch_req, 1);
        step();
        chk("R7 R6 sel back to reference", clk_sel, 0);

        // R7 search continues: one strobe relocks
        xword_found = 1'b1;
        step();
        xword_found = 1'b0;
        chk("R7 relock", lock_n, 0);
        for (int g = 0; g < 4; g++) begin
            repeat (T - 1) step();
            xword_found = 1'b1;
            step();
            xword_found = 1'b0;
            chk("R7 gap of T keeps lock", lock_n, 0);
        end
        repeat (T) step();
        chk("R7 gap of T+1 loses lock", lock_n, 1);

        // R8 idle input
        xword_found = 1'b1;
        step();
        chk("R5 lock before idle", lock_n, 0);
        repeat (3) step();
        in_active = 1'b0;
        step();
        chk("R8 idle lock_n", lock_n, 1);
        chk("R8 R11 idle force_low", force_low, 1);
        repeat (5) step();
        chk("R8 strobe ignored while idle", lock_n, 1);
        chk("R8 clock back to reference", clk_sel, 0);
        in_active = 1'b1;
        step();
        chk("R8 search resumes first", lock_n, 1);
        step();
        chk("R8 relock after activity", lock_n, 0);

        // R9 output enable
        repeat (3) step();
        oe = 1'b0;
        #1;
        chk("R9 drv_en off", drv_en, 0);
        repeat (4) step();
        chk("R9 drv_en stays off", drv_en, 0);
        oe = 1'b1;
        #1;
        chk("R9 drv_en back", drv_en, 1);
        chk("R9 lock state kept", lock_n, 0);

        // R2 power-down while locked
        pwr_n = 1'b0;
        #1;
        chk("R2 drv_en off at once", drv_en, 0);
        step();
        chk("R2 pll stopped", pll_run, 0);
        step();
        chk("R2 sel reset", clk_sel, 0);
        chk("R2 no stretch", stretch_req, 0);
        chk("R2 drv_en off with oe high", drv_en, 0);

        summary();
    end
endmodule